// File: doc/BRIEF.md
# Complementary PWM Output Stage with Dead-Time and Channel Override

This block turns a single raw PWM bit into a complementary pair of outputs, channel 0 and channel 1, for driving a half-bridge in a motor or power stage. Channel 0 follows the raw waveform and channel 1 follows its inverse. When dead-time is on, the block holds both channels inactive for a programmable number of clock cycles around every transition. This keeps the high-side and low-side switches from conducting at the same time.

After dead-time shaping, each channel passes through its own override. The override can force that pin to a fixed level whatever the waveform is doing. Commutation logic for brushless motors uses this to park a phase high or low, or to float it, while the other phase keeps switching. Period and duty generation, brake handling and register access sit outside this block.

Top module: `pwm_comp_out`

## Requirements
- R1: While `rstN` is low, both `ch0` and `ch1` are low.
- R2: When `dtEn` is 0, or `dtCount` is 0, the stage is in bypass. `ch0` equals `pwmIn` from the previous clock edge and `ch1` is its inverse.
- R3: When `dtEn` is 1 and `dtCount` = D > 0, a change on `pwmIn` drives the channel that was high low on the next edge. The other channel goes high only after exactly D clock cycles with both channels low.
- R4: Neither override bit is set means `ch0` and `ch1` are never high together, in bypass and in dead-time mode alike.
- R5: A `pwmIn` change that arrives while a dead-time window is still running restarts the window. Both channels stay low until D cycles pass with no further change.
- R6: `maskEn` bit 0 controls channel 0 and bit 1 controls channel 1. When a channel's bit is 1, that output equals the matching bit of `maskData` (bit 0 for `ch0`, bit 1 for `ch1`) from the next clock edge onward. For example, `maskEn` = 2'b10 forces only `ch1` and `maskEn` = 2'b01 forces only `ch0`. A channel whose bit is 0 keeps following the shaped waveform.
- R7: The override acts after dead-time shaping. Dead-time timing keeps running while a channel is forced, so releasing the override during a window shows that channel low until the window ends.
- R8: The window length is taken from `dtCount` at the edge where the change on `pwmIn` is seen. Later writes to `dtCount` do not alter a window that is already running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pwmIn | input | 1 | Raw PWM waveform |
| dtEn | input | 1 | Dead-time insertion enable |
| dtCount | input | CNT_W (8) | Dead-time length in clock cycles |
| maskEn | input | 2 | Per-channel override enable, bit i for channel i |
| maskData | input | 2 | Per-channel forced level, bit i for channel i |
| ch0 | output | 1 | Channel 0 output, follows the raw waveform |
| ch1 | output | 1 | Channel 1 output, complementary |

## Verification
The bench builds the block with the default 8-bit count width. This lets it reach both the one-cycle window and the longest window of 255 cycles within a short run, and it also exercises a count of zero, which falls back to bypass. A behavioural model tracks edges since the last input change and the window length captured at that change. The bench compares the model against both pins on every clock while square waves, glitch bursts, mid-window count rewrites, override patterns and random traffic are applied.

// File: rtl/pwm_out_pkg.sv
package pwm_out_pkg;
  parameter int CNT_W  = 8;
  parameter int NUM_CH = 2;

  // Strobes from the dead-time control to the output datapath
  typedef struct packed {
    logic [NUM_CH-1:0] drive;   // shaped waveform per channel
    logic              inDead;  // a dead-time window is running
  } pwmStrobe_t;
endpackage

// File: rtl/pwm_dead_ctrl.sv
module pwm_dead_ctrl
  import pwm_out_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwmIn,
  input  logic          dtEn,
  input  logic [CW-1:0] dtCount,
  output pwmStrobe_t    strb
);
  logic          lvlQ;
  logic [CW-1:0] cntQ;
  logic          dtOn;
  logic          changing;
  logic          settled;

  assign dtOn     = dtEn && (dtCount != '0);
  assign changing = (pwmIn != lvlQ);
  assign settled  = !changing && (cntQ == '0);

  // Track the last seen level and count down the window after each change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lvlQ <= 1'b0;
      cntQ <= '0;
    end else if (!dtOn) begin
      lvlQ <= pwmIn;
      cntQ <= '0;
    end else if (changing) begin
      lvlQ <= pwmIn;
      cntQ <= dtCount - 1'b1;
    end else if (cntQ != '0) begin
      cntQ <= cntQ - 1'b1;
    end
  end

  always_comb begin
    strb = '0;
    if (!dtOn) begin
      strb.drive[0] = pwmIn;
      strb.drive[1] = !pwmIn;
    end else begin
      strb.drive[0] = settled && lvlQ;
      strb.drive[1] = settled && !lvlQ;
      strb.inDead   = !settled;
    end
  end

  // R3: in dead-time mode a channel only rises after a cycle with both drives low
  a_r3_gap_before_rise : assert property (@(posedge clk) disable iff (!rstN)
    (dtOn && $past(dtOn) && ($rose(strb.drive[0]) || $rose(strb.drive[1])))
      |-> ($past(strb.drive) == '0));
endmodule

// File: rtl/pwm_mask_path.sv
module pwm_mask_path
  import pwm_out_pkg::*;
#(
  parameter int NCH = NUM_CH
) (
  input  logic           clk,
  input  logic           rstN,
  input  pwmStrobe_t     strb,
  input  logic [NCH-1:0] maskEn,
  input  logic [NCH-1:0] maskData,
  output logic [NCH-1:0] chOut
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chOut[i] <= 1'b0;
      else       chOut[i] <= maskEn[i] ? maskData[i] : strb.drive[i];
    end

    // R6: an enabled override forces the stored level on the next edge
    a_r6_mask_force : assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(maskEn[i])) |-> (chOut[i] == $past(maskData[i])));

    // R7: an unforced channel stays low while a window runs
    a_r7_dead_visible : assert property (@(posedge clk) disable iff (!rstN)
      ($past(rstN) && $past(strb.inDead) && !$past(maskEn[i])) |-> !chOut[i]);
  end

  // R1: outputs low under reset
  a_r1_reset_low : assert property (@(posedge clk) !rstN |-> (chOut == '0));

  // R4: without overrides the pair never overlaps
  a_r4_no_overlap : assert property (@(posedge clk) disable iff (!rstN)
    (chOut[0] && chOut[1]) |-> ($past(maskEn) != '0));
endmodule

// File: rtl/pwm_comp_out.sv
module pwm_comp_out
  import pwm_out_pkg::*;
#(
  parameter int CW = CNT_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          pwmIn,
  input  logic          dtEn,
  input  logic [CW-1:0] dtCount,
  input  logic [1:0]    maskEn,
  input  logic [1:0]    maskData,
  output logic          ch0,
  output logic          ch1
);
  pwmStrobe_t strb;
  logic [1:0] chOut;

  pwm_dead_ctrl #(.CW(CW)) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .pwmIn   (pwmIn),
    .dtEn    (dtEn),
    .dtCount (dtCount),
    .strb    (strb)
  );

  pwm_mask_path #(.NCH(2)) u_path (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .maskEn   (maskEn),
    .maskData (maskData),
    .chOut    (chOut)
  );

  assign ch0 = chOut[0];
  assign ch1 = chOut[1];
endmodule

// File: tb/tb_pwm_comp_out.sv
`timescale 1ns/1ps
module tb_pwm_comp_out;
  logic       clk = 1'b0;
  logic       rstN = 1'b1;
  logic       pwmIn = 1'b0;
  logic       dtEn = 1'b0;
  logic [7:0] dtCount = 8'd0;
  logic [1:0] maskEn = 2'b00;
  logic [1:0] maskData = 2'b00;
  logic       ch0, ch1;

  int    checks = 0;
  int    errors = 0;
  int    cyc = 0;
  string curReq = "R1";

  // behavioural reference state
  logic [1:0] expCh = 2'b00;
  logic       expNoMask = 1'b1;
  bit         lastRaw = 1'b0;
  int         sinceChange = 1000;
  int         winLen = 1;

  always #2 clk = ~clk;  // 250 MHz

  pwm_comp_out dut (
    .clk(clk), .rstN(rstN), .pwmIn(pwmIn), .dtEn(dtEn), .dtCount(dtCount),
    .maskEn(maskEn), .maskData(maskData), .ch0(ch0), .ch1(ch1)
  );

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // model update on each edge
  always @(posedge clk) begin
    bit g0, g1, settled;
    cyc++;
    if (!rstN) begin
      lastRaw = 1'b0; sinceChange = 1000; expCh = 2'b00; expNoMask = 1'b1;
    end else begin
      if (!(dtEn && dtCount != 0)) begin
        lastRaw = pwmIn; sinceChange = 1000;
        g0 = pwmIn; g1 = !pwmIn;
      end else begin
        if (pwmIn != lastRaw) begin
          lastRaw = pwmIn; sinceChange = 0; winLen = int'(dtCount);
        end else if (sinceChange < 1000) begin
          sinceChange++;
        end
        settled = (sinceChange >= winLen);
        g0 = settled && lastRaw;
        g1 = settled && !lastRaw;
      end
      expCh[0] = maskEn[0] ? maskData[0] : g0;
      expCh[1] = maskEn[1] ? maskData[1] : g1;
      expNoMask = (maskEn == 2'b00);
    end
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finishRun();
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    checks++;
    if ({ch1, ch0} !== expCh) begin
      errors++;
      $display("FAIL %s ch1ch0 actual %b%b expected %b%b at cycle %0d",
               curReq, ch1, ch0, expCh[1], expCh[0], cyc);
    end
    if (expNoMask && rstN) begin
      checks++;  // R4 overlap check
      if (ch0 && ch1) begin
        errors++;
        $display("FAIL R4 overlap actual 11 expected not 11 at cycle %0d", cyc);
      end
    end
  end

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic square(int halfLen, int cyclesN);
    for (int c = 0; c < cyclesN; c++) begin
      pwmIn = 1'b1; step(halfLen);
      pwmIn = 1'b0; step(halfLen);
    end
  endtask

  initial begin
    #1 rstN = 1'b0;
    curReq = "R1";
    step(5);
    rstN = 1'b1;

    curReq = "R2";  // bypass with dead-time off
    square(3, 4);
    pwmIn = 1'b1; step(1); pwmIn = 1'b0; step(2);
    dtEn = 1'b1; dtCount = 8'd0;  // zero count also bypasses
    square(2, 3);

    curReq = "R3";
    dtCount = 8'd3; square(10, 3);
    dtCount = 8'd1; square(4, 3);
    dtCount = 8'd255; square(300, 1);

    curReq = "R5";  // glitch burst restarts the window
    dtCount = 8'd5;
    pwmIn = 1'b1; step(2); pwmIn = 1'b0; step(2); pwmIn = 1'b1; step(3);
    pwmIn = 1'b0; step(12);

    curReq = "R8";  // count rewrite mid-window
    dtCount = 8'd6; pwmIn = 1'b1; step(2);
    dtCount = 8'd2; step(8);
    dtCount = 8'd20; pwmIn = 1'b0; step(3);
    dtCount = 8'd4; step(25);

    curReq = "R6";
    dtCount = 8'd3;
    maskEn = 2'b01; maskData = 2'b01; square(6, 2);
    maskEn = 2'b10; maskData = 2'b00; square(6, 2);
    maskEn = 2'b11; maskData = 2'b11; square(6, 1);
    maskEn = 2'b10; maskData = 2'b10; square(6, 1);
    maskEn = 2'b00; square(6, 1);
    dtEn = 1'b0;
    maskEn = 2'b01; maskData = 2'b00; square(4, 2);
    maskEn = 2'b00; dtEn = 1'b1;

    curReq = "R7";  // release override during a window
    dtCount = 8'd8;
    maskEn = 2'b10; maskData = 2'b10;
    pwmIn = 1'b1; step(10);
    pwmIn = 1'b0; step(3);
    maskEn = 2'b00; step(12);

    curReq = "R3";  // random traffic
    for (int i = 0; i < 400; i++) begin
      pwmIn = $urandom_range(1, 0) == 1;
      if ($urandom_range(9, 0) == 0) dtEn = $urandom_range(3, 0) != 0;
      if ($urandom_range(19, 0) == 0) dtCount = 8'($urandom_range(7, 0));
      if ($urandom_range(15, 0) == 0) begin
        maskEn = 2'($urandom_range(3, 0));
        maskData = 2'($urandom_range(3, 0));
      end
      step($urandom_range(12, 1));
    end
    maskEn = 2'b00; step(20);

    curReq = "R1";  // reset mid-run
    pwmIn = 1'b1; dtEn = 1'b0;
    step(2);
    rstN = 1'b0; step(3);
    rstN = 1'b1; step(4);

    finishRun();
  end
endmodule